// File: doc/BRIEF.md
# Software Interrupt Router with Target Filter

This block takes software-interrupt requests raised by the CPUs of a small cluster and turns them into pending state at the CPUs that should receive them. A request names the requesting CPU, an interrupt number, a filter code, a list of candidate CPUs and a secure-only flag. From the filter code the block works out a set of destination CPUs. It then drops every destination where the security configuration of that interrupt number does not match the flag. For each remaining destination it sets one pending bit, kept separately per destination, per interrupt number and per source CPU.

Each destination CPU has its own acknowledge port. The CPU names the interrupt number it wants to take; choosing that number by priority is done outside this block. The port picks the lowest-numbered source that has the number pending and clears that bit. It returns the number together with the source CPU, then holds the destination in service until an end-of-interrupt pulse. Instances of one number that come from several sources are therefore served one after another. Each destination port is a four-state machine:
- `TP_IDLE`: waits for an acknowledge. `IDLE->GRANT` when the named number has a pending source. `IDLE->REFUSE` when it has none.
- `TP_GRANT`: a one-cycle grant response. `GRANT->SERVE` always.
- `TP_REFUSE`: a one-cycle refusal response. `REFUSE->IDLE` always.
- `TP_SERVE`: in service. `SERVE->IDLE` on end-of-interrupt. `SERVE->SERVE` otherwise.

Top module: `sgi_router`

## Requirements
- R1: A request whose interrupt number is 16 or above sets no pending bit, and `req_reject` is 1 in the cycle after the request.
- R2: Filter code 0 sends the interrupt to every CPU whose bit is set in `req_targets` (bit n is CPU n).
- R3: Filter code 1 sends the interrupt to every CPU except `req_src`, whatever `req_targets` holds.
- R4: Filter code 2 sends the interrupt to `req_src` only. Filter code 3 is reserved: the request is rejected as in R1.
- R5: `sec_map[t*16+id]` = 1 marks number id as secure on CPU t. A destination receives the interrupt only when this bit equals `req_secure`. Each destination is judged on its own bit.
- R6: Pending state is one bit per destination t, number id and source s, visible at `pend_bits[t*32 + id*2 + s]`. Requests from different sources for the same number set different bits. A pending bit changes only through R6, R7 and R10, and a delivery is visible in the cycle after the request.
- R7: An acknowledge at CPU t for number id, made while the port is idle and some source has that number pending, gives `ack_valid`=1 and `ack_ok`=1 for exactly one cycle, in the cycle after the acknowledge. The response carries `ack_id`=id and the lowest-numbered pending source in `ack_src`. That pending bit is cleared.
- R8: An acknowledge for a number with no pending source gives a one-cycle response with `ack_ok`=0 and `ack_id`=id. It changes no pending bit and leaves the port idle.
- R9: From the cycle after a granted response until an `eoi` pulse, `in_service` is 1. During that time acknowledges are ignored: they give no response and clear no bit.
- R10: If a pending bit is cleared by an acknowledge and set by a new request in the same cycle, it ends set.
- R11: After reset every pending bit, `req_reject`, `ack_valid`, `ack_ok` and `in_service` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_src | input | 1 | Requesting CPU |
| req_id | input | 5 | Interrupt number, valid 0 to 15 |
| req_filter | input | 2 | 0 list, 1 all but requester, 2 requester only, 3 reserved |
| req_targets | input | 2 | Candidate CPU list for filter 0 |
| req_secure | input | 1 | Secure-only flag |
| sec_map | input | 32 | Per-CPU, per-number security setting |
| ack_req | input | 2 | Acknowledge strobe per CPU |
| ack_sel | input | 8 | Number to acknowledge, 4 bits per CPU |
| eoi | input | 2 | End-of-interrupt pulse per CPU |
| req_reject | output | 1 | Previous request was rejected |
| ack_valid | output | 2 | Acknowledge response strobe per CPU |
| ack_ok | output | 2 | Response was a grant |
| ack_id | output | 8 | Number in the response, 4 bits per CPU |
| ack_src | output | 2 | Source CPU of the granted instance |
| in_service | output | 2 | CPU is serving a granted interrupt |
| pend_bits | output | 64 | Pending bits for priority logic downstream |

## Verification
The bench goes after the cases where a plausible slip stays hidden. Two sources pend the same number on one CPU: a design that merged them would lose the second, and one that picked by the wrong order would report source 1 first. Filter codes 1 and 2 are driven with target lists that disagree with them: a design that read the list anyway would hit the wrong CPU. A number is made secure on only one CPU: a design that used a global security bit would deliver to both or to neither. Acknowledges during service and a clear that meets a new set in the same cycle are both driven: these catch a port that serves twice, or a request that gets swallowed. Random traffic with invalid numbers and the reserved filter code then runs against a bench model.

// File: rtl/sgi_pkg.sv
`timescale 1ns/1ps
package sgi_pkg;

    // Filter codes carried by a request
    typedef enum logic [1:0] {
        FLT_LIST   = 2'd0,
        FLT_OTHERS = 2'd1,
        FLT_SELF   = 2'd2,
        FLT_RSVD   = 2'd3
    } sgi_filter_e;

    // Acknowledge port states
    typedef enum logic [1:0] {
        TP_IDLE   = 2'd0,
        TP_GRANT  = 2'd1,
        TP_REFUSE = 2'd2,
        TP_SERVE  = 2'd3
    } tport_state_e;

endpackage

// File: rtl/sgi_dispatch.sv
`timescale 1ns/1ps
module sgi_dispatch
    import sgi_pkg::*;
#(
    parameter int NCPU = 2,
    parameter int NID  = 16,
    parameter int REQW = 5,
    parameter int SRCW = (NCPU > 1) ? $clog2(NCPU) : 1,
    parameter int IDW  = $clog2(NID)
) (
    input  logic                 req_valid,
    input  logic [SRCW-1:0]      req_src,
    input  logic [REQW-1:0]      req_id,
    input  logic [1:0]           req_filter,
    input  logic [NCPU-1:0]      req_targets,
    input  logic                 req_secure,
    input  logic [NCPU*NID-1:0]  sec_map,
    output logic [NCPU-1:0]      deliver,
    output logic [IDW-1:0]       set_id,
    output logic                 reject
);

    logic [NCPU-1:0] self_mask;
    logic [NCPU-1:0] route_mask;
    logic            id_ok;
    logic            filt_ok;
    sgi_filter_e     filt;

    always_comb begin
        filt    = sgi_filter_e'(req_filter);
        id_ok   = (32'(req_id) < NID);
        set_id  = req_id[IDW-1:0];
        for (int s = 0; s < NCPU; s++) begin
            self_mask[s] = (SRCW'(s) == req_src);
        end
        filt_ok = 1'b1;
        unique case (filt)
            FLT_LIST:   route_mask = req_targets;
            FLT_OTHERS: route_mask = ~self_mask;
            FLT_SELF:   route_mask = self_mask;
            FLT_RSVD: begin
                route_mask = '0;
                filt_ok    = 1'b0;
            end
        endcase
        reject = req_valid && !(id_ok && filt_ok);
        for (int t = 0; t < NCPU; t++) begin
            deliver[t] = req_valid && id_ok && filt_ok && route_mask[t]
                       && (sec_map[t*NID + int'(set_id)] == req_secure);
        end
    end

endmodule

// File: rtl/sgi_pend_bank.sv
`timescale 1ns/1ps
module sgi_pend_bank #(
    parameter int NCPU = 2,
    parameter int NID  = 16,
    parameter int SRCW = (NCPU > 1) ? $clog2(NCPU) : 1,
    parameter int IDW  = $clog2(NID)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_en,
    input  logic [IDW-1:0]       set_id,
    input  logic [SRCW-1:0]      set_src,
    input  logic                 clr_en,
    input  logic [IDW-1:0]       clr_id,
    input  logic [SRCW-1:0]      clr_src,
    input  logic [IDW-1:0]       look_id,
    output logic                 look_any,
    output logic [SRCW-1:0]      look_src,
    output logic [NID*NCPU-1:0]  pend
);

    logic [NID-1:0][NCPU-1:0] pend_q;
    logic [NID-1:0][NCPU-1:0] pend_d;

    always_comb begin
        for (int i = 0; i < NID; i++) begin
            for (int s = 0; s < NCPU; s++) begin
                pend_d[i][s] = pend_q[i][s];
                if (clr_en && clr_id == IDW'(i) && clr_src == SRCW'(s))
                    pend_d[i][s] = 1'b0;
                if (set_en && set_id == IDW'(i) && set_src == SRCW'(s))
                    pend_d[i][s] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    always_comb begin
        look_any = |pend_q[look_id];
        look_src = '0;
        for (int s = NCPU - 1; s >= 0; s--) begin
            if (pend_q[look_id][s]) look_src = SRCW'(s);
        end
    end

    assign pend = pend_q;

    // R7: only a pending instance may be taken
    a_r7_clear_was_pending: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> pend_q[clr_id][clr_src]);

    // R7: no lower-numbered source is left waiting
    a_r7_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> ((pend_q[clr_id] & ((NCPU'(1) << clr_src) - NCPU'(1))) == '0));

    // R10: a delivery always lands, even against a clear
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> pend_q[$past(set_id)][$past(set_src)]);

endmodule

// File: rtl/sgi_target_port.sv
`timescale 1ns/1ps
module sgi_target_port
    import sgi_pkg::*;
#(
    parameter int NCPU = 2,
    parameter int NID  = 16,
    parameter int SRCW = (NCPU > 1) ? $clog2(NCPU) : 1,
    parameter int IDW  = $clog2(NID)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_req,
    input  logic [IDW-1:0]   ack_sel,
    input  logic             eoi,
    input  logic             look_any,
    input  logic [SRCW-1:0]  look_src,
    output logic [IDW-1:0]   look_id,
    output logic             clr_en,
    output logic [IDW-1:0]   clr_id,
    output logic [SRCW-1:0]  clr_src,
    output logic             ack_valid,
    output logic             ack_ok,
    output logic [IDW-1:0]   ack_id,
    output logic [SRCW-1:0]  ack_src,
    output logic             in_service
);

    tport_state_e    state_q, state_d;
    logic [IDW-1:0]  id_q;
    logic [SRCW-1:0] src_q;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TP_IDLE:   if (ack_req) state_d = look_any ? TP_GRANT : TP_REFUSE;
            TP_GRANT:  state_d = TP_SERVE;
            TP_REFUSE: state_d = TP_IDLE;
            TP_SERVE:  if (eoi) state_d = TP_IDLE;
        endcase
    end

    // state register and response capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TP_IDLE;
            id_q    <= '0;
            src_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == TP_IDLE && ack_req) begin
                id_q  <= ack_sel;
                src_q <= look_any ? look_src : '0;
            end
        end
    end

    // outputs
    always_comb begin
        look_id    = ack_sel;
        clr_id     = ack_sel;
        clr_src    = look_src;
        clr_en     = (state_q == TP_IDLE) && ack_req && look_any;
        ack_valid  = (state_q == TP_GRANT) || (state_q == TP_REFUSE);
        ack_ok     = (state_q == TP_GRANT);
        ack_id     = id_q;
        ack_src    = src_q;
        in_service = (state_q == TP_SERVE);
    end

    // R7: a response lasts exactly one cycle
    a_r7_response_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> !ack_valid);

    // R7: a grant is followed by service
    a_r7_grant_then_serve: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_ok) |=> in_service);

    // R9: in service, nothing answers and service holds until eoi
    a_r9_serve_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (in_service && !eoi) |=> (in_service && !ack_valid));

    // R9: no pending bit is taken while serving
    a_r9_no_take_in_service: assert property (@(posedge clk) disable iff (!rst_n)
        in_service |-> !clr_en);

endmodule

// File: rtl/sgi_router.sv
`timescale 1ns/1ps
module sgi_router #(
    parameter int NCPU = 2,
    parameter int NID  = 16,
    parameter int REQW = 5,
    parameter int SRCW = (NCPU > 1) ? $clog2(NCPU) : 1,
    parameter int IDW  = $clog2(NID)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [SRCW-1:0]           req_src,
    input  logic [REQW-1:0]           req_id,
    input  logic [1:0]                req_filter,
    input  logic [NCPU-1:0]           req_targets,
    input  logic                      req_secure,
    input  logic [NCPU*NID-1:0]       sec_map,
    input  logic [NCPU-1:0]           ack_req,
    input  logic [NCPU*IDW-1:0]       ack_sel,
    input  logic [NCPU-1:0]           eoi,
    output logic                      req_reject,
    output logic [NCPU-1:0]           ack_valid,
    output logic [NCPU-1:0]           ack_ok,
    output logic [NCPU*IDW-1:0]       ack_id,
    output logic [NCPU*SRCW-1:0]      ack_src,
    output logic [NCPU-1:0]           in_service,
    output logic [NCPU*NID*NCPU-1:0]  pend_bits
);

    localparam int BANKW = NID * NCPU;

    logic [NCPU-1:0] deliver;
    logic [IDW-1:0]  set_id;
    logic            reject;

    sgi_dispatch #(.NCPU(NCPU), .NID(NID), .REQW(REQW), .SRCW(SRCW), .IDW(IDW)) u_dispatch (
        .req_valid   (req_valid),
        .req_src     (req_src),
        .req_id      (req_id),
        .req_filter  (req_filter),
        .req_targets (req_targets),
        .req_secure  (req_secure),
        .sec_map     (sec_map),
        .deliver     (deliver),
        .set_id      (set_id),
        .reject      (reject)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_reject <= 1'b0;
        else        req_reject <= reject;
    end

    for (genvar t = 0; t < NCPU; t++) begin : g_cpu
        logic            look_any;
        logic [SRCW-1:0] look_src;
        logic [IDW-1:0]  look_id;
        logic            clr_en;
        logic [IDW-1:0]  clr_id;
        logic [SRCW-1:0] clr_src;

        sgi_pend_bank #(.NCPU(NCPU), .NID(NID), .SRCW(SRCW), .IDW(IDW)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_en   (deliver[t]),
            .set_id   (set_id),
            .set_src  (req_src),
            .clr_en   (clr_en),
            .clr_id   (clr_id),
            .clr_src  (clr_src),
            .look_id  (look_id),
            .look_any (look_any),
            .look_src (look_src),
            .pend     (pend_bits[t*BANKW +: BANKW])
        );

        sgi_target_port #(.NCPU(NCPU), .NID(NID), .SRCW(SRCW), .IDW(IDW)) u_port (
            .clk        (clk),
            .rst_n      (rst_n),
            .ack_req    (ack_req[t]),
            .ack_sel    (ack_sel[t*IDW +: IDW]),
            .eoi        (eoi[t]),
            .look_any   (look_any),
            .look_src   (look_src),
            .look_id    (look_id),
            .clr_en     (clr_en),
            .clr_id     (clr_id),
            .clr_src    (clr_src),
            .ack_valid  (ack_valid[t]),
            .ack_ok     (ack_ok[t]),
            .ack_id     (ack_id[t*IDW +: IDW]),
            .ack_src    (ack_src[t*SRCW +: SRCW]),
            .in_service (in_service[t])
        );

        // R5: a destination whose security bit mismatches gains nothing from the request
        a_r5_security_gate: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && (32'(req_id) < NID) && !clr_en
             && sec_map[t*NID + int'(req_id[IDW-1:0])] != req_secure)
            |=> $stable(pend_bits[t*BANKW +: BANKW]));
    end

    // R1: out-of-range numbers are refused
    a_r1_bad_id_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && 32'(req_id) >= NID) |=> req_reject);

    // R4: the reserved filter code is refused
    a_r4_rsvd_filter_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_filter == 2'd3) |=> req_reject);

endmodule

// File: tb/sgi_router_test.sv
`timescale 1ns/1ps
module sgi_router_test;

    localparam int NC = 2;
    localparam int NI = 16;
    localparam int PW = NC * NI * NC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_src = 1'b0;
    logic [4:0]    req_id = '0;
    logic [1:0]    req_filter = '0;
    logic [1:0]    req_targets = '0;
    logic          req_secure = 1'b0;
    logic [31:0]   sec_map = '0;
    logic [1:0]    ack_req = '0;
    logic [7:0]    ack_sel = '0;
    logic [1:0]    eoi = '0;
    logic          req_reject;
    logic [1:0]    ack_valid;
    logic [1:0]    ack_ok;
    logic [7:0]    ack_id;
    logic [1:0]    ack_src;
    logic [1:0]    in_service;
    logic [PW-1:0] pend_bits;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    bit mp [NC][NI][NC];
    bit busy [NC];

    always #10 clk = ~clk;

    sgi_router uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
        .req_id(req_id), .req_filter(req_filter), .req_targets(req_targets),
        .req_secure(req_secure), .sec_map(sec_map), .ack_req(ack_req),
        .ack_sel(ack_sel), .eoi(eoi), .req_reject(req_reject),
        .ack_valid(ack_valid), .ack_ok(ack_ok), .ack_id(ack_id),
        .ack_src(ack_src), .in_service(in_service), .pend_bits(pend_bits)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] model_vec();
        logic [PW-1:0] v = '0;
        for (int t = 0; t < NC; t++)
            for (int i = 0; i < NI; i++)
                for (int s = 0; s < NC; s++)
                    v[t*NI*NC + i*NC + s] = mp[t][i][s];
        return v;
    endfunction

    function automatic logic [1:0] route(input int src, input int filt, input logic [1:0] tl);
        logic [1:0] self = 2'b01 << src;
        case (filt)
            0: return tl;
            1: return ~self;
            2: return self;
            default: return 2'b00;
        endcase
    endfunction

    function automatic bit is_reject(input int id, input int filt);
        return (id >= NI) || (filt == 3);
    endfunction

    task automatic model_request(input int src, input int id, input int filt,
                                 input logic [1:0] tl, input bit sec);
        logic [1:0] m;
        if (is_reject(id, filt)) return;
        m = route(src, filt, tl);
        for (int t = 0; t < NC; t++)
            if (m[t] && (sec_map[t*NI + id] == sec)) mp[t][id][src] = 1'b1;
    endtask

    // returns 1 with src when a grant is expected; updates model
    task automatic model_ack(input int t, input int id, output bit ok, output int src);
        ok = 0; src = 0;
        for (int s = NC - 1; s >= 0; s--)
            if (mp[t][id][s]) begin ok = 1; src = s; end
        if (ok) mp[t][id][src] = 1'b0;
    endtask

    task automatic drive_req(input int src, input int id, input int filt,
                             input logic [1:0] tl, input bit sec);
        req_valid = 1'b1; req_src = src[0]; req_id = id[4:0];
        req_filter = filt[1:0]; req_targets = tl; req_secure = sec;
    endtask

    task automatic do_req(input string tag, input int src, input int id, input int filt,
                          input logic [1:0] tl, input bit sec);
        @(negedge clk);
        drive_req(src, id, filt, tl, sec);
        model_request(src, id, filt, tl, sec);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_reject == is_reject(id, filt), tag, "reject", req_reject, is_reject(id, filt));
        chk(pend_bits == model_vec(), tag, "pending", pend_bits, model_vec());
    endtask

    task automatic check_ack(input string tag, input int t, input int id,
                             input bit was_busy, input bit ok, input int src);
        if (was_busy) begin
            chk(ack_valid[t] == 1'b0, tag, "no response in service", ack_valid[t], 0);
        end else begin
            chk(ack_valid[t] == 1'b1, tag, "response valid", ack_valid[t], 1);
            chk(ack_ok[t] == ok, tag, "response ok", ack_ok[t], ok);
            chk(ack_id[t*4 +: 4] == id[3:0], tag, "response id", ack_id[t*4 +: 4], id);
            if (ok) chk(ack_src[t] == src[0], tag, "response source", ack_src[t], src);
        end
        chk(pend_bits == model_vec(), tag, "pending after ack", pend_bits, model_vec());
    endtask

    task automatic do_ack(input string tag, input int t, input int id);
        bit ok; int src; bit wb;
        @(negedge clk);
        wb = busy[t];
        ack_req[t] = 1'b1; ack_sel[t*4 +: 4] = id[3:0];
        if (!wb) model_ack(t, id, ok, src); else begin ok = 0; src = 0; end
        @(negedge clk);
        ack_req[t] = 1'b0;
        check_ack(tag, t, id, wb, ok, src);
        if (!wb && ok) busy[t] = 1;
        @(negedge clk);
        chk(in_service[t] == busy[t], tag, "in service", in_service[t], busy[t]);
    endtask

    task automatic do_both(input string tag, input int t, input int id, input int src,
                           input int filt, input logic [1:0] tl, input bit sec);
        bit ok; int asrc;
        @(negedge clk);
        ack_req[t] = 1'b1; ack_sel[t*4 +: 4] = id[3:0];
        drive_req(src, id, filt, tl, sec);
        model_ack(t, id, ok, asrc);
        model_request(src, id, filt, tl, sec);
        @(negedge clk);
        ack_req[t] = 1'b0; req_valid = 1'b0;
        check_ack(tag, t, id, 1'b0, ok, asrc);
        if (ok) busy[t] = 1;
        @(negedge clk);
    endtask

    task automatic do_eoi(input int t);
        @(negedge clk);
        eoi[t] = 1'b1;
        @(negedge clk);
        eoi[t] = 1'b0;
        busy[t] = 0;
        chk(in_service[t] == 1'b0, "R9", "service ends on eoi", in_service[t], 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd71523));
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(pend_bits == '0, "R11", "pending at reset", pend_bits, 0);
        chk(req_reject == 1'b0, "R11", "reject at reset", req_reject, 0);
        chk(ack_valid == 2'b00 && ack_ok == 2'b00, "R11", "response at reset", ack_valid, 0);
        chk(in_service == 2'b00, "R11", "service at reset", in_service, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: list filter to both CPUs; R6: a second source for the same number
        do_req("R2", 0, 3, 0, 2'b11, 1'b0);
        do_req("R6", 1, 3, 0, 2'b01, 1'b0);
        // R7: lowest source first; R9: ack while serving is ignored
        do_ack("R7", 0, 3);
        do_ack("R9", 0, 3);
        do_eoi(0);
        do_ack("R7", 0, 3);
        do_eoi(0);
        do_ack("R7", 1, 3);
        do_eoi(1);
        // R3: all but requester, list says requester only
        do_req("R3", 0, 5, 1, 2'b01, 1'b0);
        // R4: requester only, list says the other CPU; then reserved code
        do_req("R4", 1, 6, 2, 2'b01, 1'b0);
        do_req("R4", 0, 6, 3, 2'b11, 1'b0);
        // R1: out-of-range numbers
        do_req("R1", 0, 16, 0, 2'b11, 1'b0);
        do_req("R1", 1, 31, 2, 2'b11, 1'b0);
        // R5: number 7 secure on CPU 1 only
        sec_map[1*NI + 7] = 1'b1;
        do_req("R5", 0, 7, 0, 2'b11, 1'b1);
        do_req("R5", 1, 7, 0, 2'b11, 1'b0);
        // R8: nothing pending
        do_ack("R8", 1, 9);
        // R10: clear and set of the same bit in one cycle
        do_req("R10", 0, 8, 2, 2'b00, 1'b0);
        do_both("R10", 0, 8, 0, 2, 2'b00, 1'b0);
        do_eoi(0);

        // constrained random traffic
        for (int n = 0; n < 400; n++) begin
            int op = $urandom % 10;
            if (op < 5) begin
                do_req("R6", $urandom % 2, $urandom % 20, $urandom % 4,
                       2'($urandom % 4), 1'($urandom % 2));
            end else if (op < 8) begin
                int t = $urandom % 2;
                int id = ($urandom % 2) ? 32'(req_id[3:0]) : ($urandom % 16);
                do_ack("R7", t, id);
            end else if (op == 8) begin
                do_eoi($urandom % 2);
            end else begin
                sec_map = $urandom;
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule